// File: doc/BRIEF.md
# Location-Tracking Extended TLB

This block is a small, fully associative translation buffer. Each entry stores a virtual-to-physical page mapping and, for every cache block inside that page, the block's location in an exclusive two-level cache hierarchy. The location has three parts: a present bit, the way that holds the block, and the holder level, L1 or L2. Because the location comes out of the translation lookup, a hit finds the data without a tag compare at either cache level.

A lookup presents an address-space identifier (ASID) and a virtual address. One cycle later the block returns one of three results. The block may be cached, in which case the result gives its way and holder. It may be uncached, in which case the result gives the physical address for a memory fetch. Otherwise the translation missed. Every result that matches an entry also reports the entry index, so the surrounding logic can address later fills and updates to that entry.

Several side ports keep the location state current. A refill port installs a complete entry delivered by the directory. Installing into an occupied slot sends the displaced entry out on a write-back port. A fill port marks a block as present in L1 once a memory fetch completes. An update port rewrites one block's location after eviction traffic. A synonym port retags an existing entry to a new virtual page and ASID and keeps its location state.

Top module: `xlat_loc_tlb`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid` and `wb_valid` are low, and every lookup returns kind 0 (miss).
- R2: A lookup hits only when the entry is valid and both its virtual page number and its ASID equal the request's. Any other lookup returns kind 0, so two pages with the same virtual page number and different ASIDs stay distinct.
- R3: On a hit where the addressed block is present, `rsp_kind` is 1 (cached). `rsp_way` and `rsp_comp` give the stored way and holder (0 = L1, 1 = L2). `rsp_pa` is the entry's physical page number concatenated with the page offset of the request, and `rsp_idx` gives the entry index.
- R4: On a hit where the addressed block is absent, `rsp_kind` is 2 (uncached) and `rsp_pa` carries the translated physical address.
- R5: `rsp_valid` is high exactly in the cycle after a cycle with `lk_req` high.
- R6: A refill goes into the lowest-numbered invalid entry. When every entry is valid, it goes into the entry named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, on each such replacement.
- R7: When a refill displaces a valid entry, the next cycle shows `wb_valid` high together with that entry's ASID, page numbers and complete per-block present, way and holder state. When the refill lands in an invalid entry, `wb_valid` stays low. Block state in the block itself is never cleared by a replacement; the whole entry is handed out.
- R8: A fill at (entry, block) sets that block present, with holder L1 and the given way.
- R9: An update at (entry, block) sets that block's present bit, way and holder to the given values. An update wins over a fill to the same block in the same cycle.
- R10: A lookup in the same cycle as a fill or update to the block it addresses reports the newly written location.
- R11: A synonym install rewrites only the virtual page number and ASID of the named entry. The physical page and all location state are kept, the old tag no longer hits, and no write-back is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_asid | input | ASID_W | Lookup ASID |
| lk_va | input | VA_W | Lookup virtual address |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_kind | output | 2 | 0 miss, 1 cached, 2 uncached |
| rsp_way | output | WAY_W | Way holding the block |
| rsp_comp | output | 1 | Holder level: 0 L1, 1 L2 |
| rsp_pa | output | PA_W | Translated physical address |
| rsp_idx | output | IDX_W | Index of the matching entry |
| fill_en | input | 1 | Fill completion strobe |
| fill_idx | input | IDX_W | Fill entry index |
| fill_off | input | OFF_W | Fill block offset within page |
| fill_way | input | WAY_W | Way written by the fill |
| upd_en | input | 1 | Location update strobe |
| upd_idx | input | IDX_W | Update entry index |
| upd_off | input | OFF_W | Update block offset within page |
| upd_vld | input | 1 | New present bit |
| upd_way | input | WAY_W | New way |
| upd_comp | input | 1 | New holder level |
| rf_en | input | 1 | Directory refill strobe |
| rf_asid | input | ASID_W | Refill ASID |
| rf_vpn | input | VPN_W | Refill virtual page number |
| rf_ppn | input | PPN_W | Refill physical page number |
| rf_vld | input | BLKS | Refill per-block present bits |
| rf_way | input | BLKS*WAY_W | Refill per-block ways, block b at bits [b*WAY_W +: WAY_W] |
| rf_comp | input | BLKS | Refill per-block holder levels |
| syn_en | input | 1 | Synonym retag strobe |
| syn_idx | input | IDX_W | Entry to retag |
| syn_asid | input | ASID_W | New ASID |
| syn_vpn | input | VPN_W | New virtual page number |
| wb_valid | output | 1 | Displaced entry valid |
| wb_asid | output | ASID_W | Displaced ASID |
| wb_vpn | output | VPN_W | Displaced virtual page number |
| wb_ppn | output | PPN_W | Displaced physical page number |
| wb_vld | output | BLKS | Displaced per-block present bits |
| wb_way | output | BLKS*WAY_W | Displaced per-block ways |
| wb_comp | output | BLKS | Displaced per-block holder levels |

## Verification
The bench builds the block with 4 entries, 64-byte pages and 16-byte blocks, which gives four blocks per page, 2-bit ways and 12-bit addresses. At that size it can write every combination of way and holder into every block of every entry and read each one back. It also walks the round-robin victim pointer through a complete wrap and checks each displaced entry field by field. Homonym misses, same-cycle forwarding, the fill path and synonym retagging are checked against a small arithmetic model of the entry table that the bench keeps.

// File: rtl/ltlb_pkg.sv
package ltlb_pkg;

    typedef enum logic [1:0] {
        RES_MISS     = 2'd0,
        RES_CACHED   = 2'd1,
        RES_UNCACHED = 2'd2
    } res_kind_e;

    typedef enum logic {
        HOLD_L1 = 1'b0,
        HOLD_L2 = 1'b1
    } holder_e;

    function automatic int blocks_per_page(input int page_bits, input int blk_bits);
        return 1 << (page_bits - blk_bits);
    endfunction

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ltlb_match.sv
module ltlb_match #(
    parameter  int ENTRIES = 16,
    parameter  int TAG_W   = 28,
    localparam int IDX_W   = ltlb_pkg::idx_width(ENTRIES)
) (
    input  logic [ENTRIES-1:0]       live,
    input  logic [ENTRIES*TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]         key,
    output logic                     hit,
    output logic [IDX_W-1:0]         hit_idx
);
    logic [ENTRIES-1:0] hv;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hv[g] = live[g] && (tags[g*TAG_W +: TAG_W] == key);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hv[i]) hit_idx = hit_idx | IDX_W'(i);
        end
    end

    assign hit = |hv;
endmodule

// File: rtl/ltlb_victim.sv
module ltlb_victim #(
    parameter  int ENTRIES = 16,
    localparam int IDX_W   = ltlb_pkg::idx_width(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] live,
    input  logic               alloc,
    output logic [IDX_W-1:0]   vic_idx,
    output logic               vic_live
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             free_found;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!live[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    assign vic_idx  = free_found ? free_idx : rr_q;
    assign vic_live = !free_found;

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (alloc && !free_found) begin
            rr_q <= (int'(rr_q) == ENTRIES - 1) ? '0 : rr_q + 1'b1;
        end
    end

    // R6
    rr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(rr_q) < ENTRIES);
endmodule

// File: rtl/xlat_loc_tlb.sv
module xlat_loc_tlb
    import ltlb_pkg::*;
#(
    parameter  int ENTRIES   = 16,
    parameter  int VA_W      = 32,
    parameter  int PA_W      = 32,
    parameter  int PAGE_BITS = 12,
    parameter  int BLK_BITS  = 6,
    parameter  int WAY_W     = 2,
    parameter  int ASID_W    = 8,
    localparam int BLKS      = blocks_per_page(PAGE_BITS, BLK_BITS),
    localparam int OFF_W     = PAGE_BITS - BLK_BITS,
    localparam int VPN_W     = VA_W - PAGE_BITS,
    localparam int PPN_W     = PA_W - PAGE_BITS,
    localparam int IDX_W     = idx_width(ENTRIES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  lk_req,
    input  logic [ASID_W-1:0]     lk_asid,
    input  logic [VA_W-1:0]       lk_va,
    output logic                  rsp_valid,
    output logic [1:0]            rsp_kind,
    output logic [WAY_W-1:0]      rsp_way,
    output logic                  rsp_comp,
    output logic [PA_W-1:0]       rsp_pa,
    output logic [IDX_W-1:0]      rsp_idx,
    input  logic                  fill_en,
    input  logic [IDX_W-1:0]      fill_idx,
    input  logic [OFF_W-1:0]      fill_off,
    input  logic [WAY_W-1:0]      fill_way,
    input  logic                  upd_en,
    input  logic [IDX_W-1:0]      upd_idx,
    input  logic [OFF_W-1:0]      upd_off,
    input  logic                  upd_vld,
    input  logic [WAY_W-1:0]      upd_way,
    input  logic                  upd_comp,
    input  logic                  rf_en,
    input  logic [ASID_W-1:0]     rf_asid,
    input  logic [VPN_W-1:0]      rf_vpn,
    input  logic [PPN_W-1:0]      rf_ppn,
    input  logic [BLKS-1:0]       rf_vld,
    input  logic [BLKS*WAY_W-1:0] rf_way,
    input  logic [BLKS-1:0]       rf_comp,
    input  logic                  syn_en,
    input  logic [IDX_W-1:0]      syn_idx,
    input  logic [ASID_W-1:0]     syn_asid,
    input  logic [VPN_W-1:0]      syn_vpn,
    output logic                  wb_valid,
    output logic [ASID_W-1:0]     wb_asid,
    output logic [VPN_W-1:0]      wb_vpn,
    output logic [PPN_W-1:0]      wb_ppn,
    output logic [BLKS-1:0]       wb_vld,
    output logic [BLKS*WAY_W-1:0] wb_way,
    output logic [BLKS-1:0]       wb_comp
);
    localparam int TAG_W = ASID_W + VPN_W;

    // entry table
    logic [ENTRIES-1:0]    e_live;
    logic [ASID_W-1:0]     e_asid [ENTRIES];
    logic [VPN_W-1:0]      e_vpn  [ENTRIES];
    logic [PPN_W-1:0]      e_ppn  [ENTRIES];
    logic [BLKS-1:0]       e_bv   [ENTRIES];
    logic [BLKS*WAY_W-1:0] e_bw   [ENTRIES];
    logic [BLKS-1:0]       e_bc   [ENTRIES];

    logic [ENTRIES*TAG_W-1:0] tag_flat;
    for (genvar g = 0; g < ENTRIES; g++) begin : g_tag
        assign tag_flat[g*TAG_W +: TAG_W] = {e_asid[g], e_vpn[g]};
    end

    logic [VPN_W-1:0] lk_vpn;
    logic [OFF_W-1:0] lk_off;
    assign lk_vpn = lk_va[VA_W-1:PAGE_BITS];
    assign lk_off = lk_va[PAGE_BITS-1:BLK_BITS];

    logic             m_hit;
    logic [IDX_W-1:0] m_idx;
    logic [IDX_W-1:0] v_idx;
    logic             v_live;

    ltlb_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_match (
        .live    (e_live),
        .tags    (tag_flat),
        .key     ({lk_asid, lk_vpn}),
        .hit     (m_hit),
        .hit_idx (m_idx)
    );

    ltlb_victim #(.ENTRIES(ENTRIES)) u_vict (
        .clk      (clk),
        .rst      (rst),
        .live     (e_live),
        .alloc    (rf_en),
        .vic_idx  (v_idx),
        .vic_live (v_live)
    );

    // block location seen by the lookup, with same-cycle writes forwarded
    logic             f_v;
    logic [WAY_W-1:0] f_w;
    holder_e          f_c;

    always_comb begin
        f_v = e_bv[m_idx][lk_off];
        f_w = e_bw[m_idx][int'(lk_off)*WAY_W +: WAY_W];
        f_c = holder_e'(e_bc[m_idx][lk_off]);
        if (fill_en && fill_idx == m_idx && fill_off == lk_off) begin
            f_v = 1'b1;
            f_w = fill_way;
            f_c = HOLD_L1;
        end
        if (upd_en && upd_idx == m_idx && upd_off == lk_off) begin
            f_v = upd_vld;
            f_w = upd_way;
            f_c = holder_e'(upd_comp);
        end
    end

    res_kind_e kind_q;
    assign rsp_kind = kind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            kind_q    <= RES_MISS;
            rsp_way   <= '0;
            rsp_comp  <= 1'b0;
            rsp_pa    <= '0;
            rsp_idx   <= '0;
        end else begin
            rsp_valid <= lk_req;
            if (lk_req) begin
                kind_q   <= !m_hit ? RES_MISS : (f_v ? RES_CACHED : RES_UNCACHED);
                rsp_way  <= f_w;
                rsp_comp <= f_c;
                rsp_pa   <= {e_ppn[m_idx], lk_va[PAGE_BITS-1:0]};
                rsp_idx  <= m_idx;
            end
        end
    end

    // table writes: later statements win (fill < update < refill)
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                e_live[i] <= 1'b0;
                e_asid[i] <= '0;
                e_vpn[i]  <= '0;
                e_ppn[i]  <= '0;
                e_bv[i]   <= '0;
                e_bw[i]   <= '0;
                e_bc[i]   <= '0;
            end
        end else begin
            if (fill_en) begin
                e_bv[fill_idx][fill_off]                         <= 1'b1;
                e_bw[fill_idx][int'(fill_off)*WAY_W +: WAY_W]    <= fill_way;
                e_bc[fill_idx][fill_off]                         <= HOLD_L1;
            end
            if (upd_en) begin
                e_bv[upd_idx][upd_off]                           <= upd_vld;
                e_bw[upd_idx][int'(upd_off)*WAY_W +: WAY_W]      <= upd_way;
                e_bc[upd_idx][upd_off]                           <= upd_comp;
            end
            if (rf_en) begin
                e_live[v_idx] <= 1'b1;
                e_asid[v_idx] <= rf_asid;
                e_vpn[v_idx]  <= rf_vpn;
                e_ppn[v_idx]  <= rf_ppn;
                e_bv[v_idx]   <= rf_vld;
                e_bw[v_idx]   <= rf_way;
                e_bc[v_idx]   <= rf_comp;
            end else if (syn_en) begin
                e_asid[syn_idx] <= syn_asid;
                e_vpn[syn_idx]  <= syn_vpn;
            end
        end
    end

    // displaced entry
    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid <= 1'b0;
            wb_asid  <= '0;
            wb_vpn   <= '0;
            wb_ppn   <= '0;
            wb_vld   <= '0;
            wb_way   <= '0;
            wb_comp  <= '0;
        end else begin
            wb_valid <= rf_en && v_live;
            if (rf_en) begin
                wb_asid <= e_asid[v_idx];
                wb_vpn  <= e_vpn[v_idx];
                wb_ppn  <= e_ppn[v_idx];
                wb_vld  <= e_bv[v_idx];
                wb_way  <= e_bw[v_idx];
                wb_comp <= e_bc[v_idx];
            end
        end
    end

    // R5
    rsp_lat_chk: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> rsp_valid);
    // R5
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> !rsp_valid);
    // R7
    wb_cause_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> $past(rf_en));
    // R6
    vic_free_chk: assert property (@(posedge clk) disable iff (rst)
        (rf_en && !(&e_live)) |-> !v_live);
    // R1
    empty_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(e_live) == '0) |-> rsp_kind == RES_MISS);
endmodule

// File: tb/sim_xlat_loc_tlb.sv
`timescale 1ns/1ps
module sim_xlat_loc_tlb;
    localparam int NE = 4;
    localparam int NB = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst;
    logic        lk_req;
    logic [1:0]  lk_asid;
    logic [11:0] lk_va;
    logic        rsp_valid;
    logic [1:0]  rsp_kind;
    logic [1:0]  rsp_way;
    logic        rsp_comp;
    logic [11:0] rsp_pa;
    logic [1:0]  rsp_idx;
    logic        fill_en;
    logic [1:0]  fill_idx, fill_off, fill_way;
    logic        upd_en;
    logic [1:0]  upd_idx, upd_off, upd_way;
    logic        upd_vld, upd_comp;
    logic        rf_en;
    logic [1:0]  rf_asid;
    logic [5:0]  rf_vpn, rf_ppn;
    logic [3:0]  rf_vld, rf_comp;
    logic [7:0]  rf_way;
    logic        syn_en;
    logic [1:0]  syn_idx, syn_asid;
    logic [5:0]  syn_vpn;
    logic        wb_valid;
    logic [1:0]  wb_asid;
    logic [5:0]  wb_vpn, wb_ppn;
    logic [3:0]  wb_vld, wb_comp;
    logic [7:0]  wb_way;

    xlat_loc_tlb #(.ENTRIES(NE), .VA_W(12), .PA_W(12), .PAGE_BITS(6),
                   .BLK_BITS(4), .WAY_W(2), .ASID_W(2)) u0 (.*);

    int total = 0;
    int bad   = 0;

    // reference table
    logic       m_live [NE];
    logic [1:0] m_asid [NE];
    logic [5:0] m_vpn  [NE];
    logic [5:0] m_ppn  [NE];
    logic [3:0] m_bv   [NE];
    logic [7:0] m_bw   [NE];
    logic [3:0] m_bc   [NE];
    int         m_rr;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int find(input logic [1:0] a, input logic [5:0] v);
        for (int i = 0; i < NE; i++)
            if (m_live[i] && m_asid[i] == a && m_vpn[i] == v) return i;
        return -1;
    endfunction

    task automatic expect_look(input logic [1:0] a, input logic [11:0] va, input string tag);
        int e;
        int off;
        string t;
        e   = find(a, va[11:6]);
        off = int'(va[5:4]);
        check("R5", "rsp_valid", rsp_valid, 1);
        if (e < 0) begin
            t = (tag == "") ? "R2" : tag;
            check(t, "kind(miss)", rsp_kind, 0);
        end else begin
            t = (tag == "") ? (m_bv[e][off] ? "R3" : "R4") : tag;
            check(t, "idx", rsp_idx, e);
            check(t, "pa", rsp_pa, {m_ppn[e], va[5:0]});
            if (m_bv[e][off]) begin
                check(t, "kind(cached)", rsp_kind, 1);
                check(t, "way", rsp_way, m_bw[e][off*2 +: 2]);
                check(t, "comp", rsp_comp, m_bc[e][off]);
            end else begin
                check(t, "kind(uncached)", rsp_kind, 2);
            end
        end
    endtask

    task automatic look(input logic [1:0] a, input logic [11:0] va, input string tag);
        @(negedge clk);
        lk_req = 1'b1; lk_asid = a; lk_va = va;
        @(negedge clk);
        lk_req = 1'b0;
        expect_look(a, va, tag);
    endtask

    task automatic m_set(input int e, input int off, input logic v,
                         input logic [1:0] w, input logic c);
        m_bv[e][off]       = v;
        m_bw[e][off*2 +: 2] = w;
        m_bc[e][off]       = c;
    endtask

    task automatic upd(input int e, input int off, input logic v,
                       input logic [1:0] w, input logic c);
        @(negedge clk);
        upd_en = 1'b1; upd_idx = 2'(e); upd_off = 2'(off);
        upd_vld = v; upd_way = w; upd_comp = c;
        @(negedge clk);
        upd_en = 1'b0;
        m_set(e, off, v, w, c);
    endtask

    task automatic fill(input int e, input int off, input logic [1:0] w);
        @(negedge clk);
        fill_en = 1'b1; fill_idx = 2'(e); fill_off = 2'(off); fill_way = w;
        @(negedge clk);
        fill_en = 1'b0;
        m_set(e, off, 1'b1, w, 1'b0);
    endtask

    task automatic upd_look(input int e, input int off, input logic v,
                            input logic [1:0] w, input logic c);
        @(negedge clk);
        upd_en = 1'b1; upd_idx = 2'(e); upd_off = 2'(off);
        upd_vld = v; upd_way = w; upd_comp = c;
        lk_req = 1'b1; lk_asid = m_asid[e]; lk_va = {m_vpn[e], 2'(off), 4'h9};
        @(negedge clk);
        upd_en = 1'b0; lk_req = 1'b0;
        m_set(e, off, v, w, c);
        expect_look(m_asid[e], {m_vpn[e], 2'(off), 4'h9}, "R10");
    endtask

    task automatic fill_look(input int e, input int off, input logic [1:0] w);
        @(negedge clk);
        fill_en = 1'b1; fill_idx = 2'(e); fill_off = 2'(off); fill_way = w;
        lk_req = 1'b1; lk_asid = m_asid[e]; lk_va = {m_vpn[e], 2'(off), 4'h2};
        @(negedge clk);
        fill_en = 1'b0; lk_req = 1'b0;
        m_set(e, off, 1'b1, w, 1'b0);
        expect_look(m_asid[e], {m_vpn[e], 2'(off), 4'h2}, "R10");
    endtask

    task automatic refill(input logic [1:0] a, input logic [5:0] v, input logic [5:0] p,
                          input logic [3:0] bv, input logic [7:0] bw, input logic [3:0] bc);
        int vic;
        logic ewb;
        vic = -1;
        for (int i = NE - 1; i >= 0; i--) if (!m_live[i]) vic = i;
        ewb = (vic < 0);
        if (ewb) begin
            vic  = m_rr;
            m_rr = (m_rr + 1) % NE;
        end
        @(negedge clk);
        rf_en = 1'b1; rf_asid = a; rf_vpn = v; rf_ppn = p;
        rf_vld = bv; rf_way = bw; rf_comp = bc;
        @(negedge clk);
        rf_en = 1'b0;
        check("R7", "wb_valid", wb_valid, ewb);
        if (ewb) begin
            check("R7", "wb_asid", wb_asid, m_asid[vic]);
            check("R7", "wb_vpn",  wb_vpn,  m_vpn[vic]);
            check("R7", "wb_ppn",  wb_ppn,  m_ppn[vic]);
            check("R7", "wb_vld",  wb_vld,  m_bv[vic]);
            check("R7", "wb_way",  wb_way,  m_bw[vic]);
            check("R7", "wb_comp", wb_comp, m_bc[vic]);
        end
        m_live[vic] = 1'b1; m_asid[vic] = a; m_vpn[vic] = v; m_ppn[vic] = p;
        m_bv[vic] = bv; m_bw[vic] = bw; m_bc[vic] = bc;
        look(a, {v, 6'h05}, "R6");
    endtask

    task automatic syn(input int e, input logic [1:0] a, input logic [5:0] v);
        @(negedge clk);
        syn_en = 1'b1; syn_idx = 2'(e); syn_asid = a; syn_vpn = v;
        @(negedge clk);
        syn_en = 1'b0;
        check("R11", "no wb", wb_valid, 0);
        m_asid[e] = a; m_vpn[e] = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [1:0] oa;
        logic [5:0] ov;
        rst = 1'b1;
        lk_req = 0; lk_asid = 0; lk_va = 0;
        fill_en = 0; fill_idx = 0; fill_off = 0; fill_way = 0;
        upd_en = 0; upd_idx = 0; upd_off = 0; upd_way = 0; upd_vld = 0; upd_comp = 0;
        rf_en = 0; rf_asid = 0; rf_vpn = 0; rf_ppn = 0; rf_vld = 0; rf_way = 0; rf_comp = 0;
        syn_en = 0; syn_idx = 0; syn_asid = 0; syn_vpn = 0;
        for (int i = 0; i < NE; i++) begin
            m_live[i] = 0; m_asid[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0;
            m_bv[i] = 0; m_bw[i] = 0; m_bc[i] = 0;
        end
        m_rr = 0;
        repeat (3) @(negedge clk);
        check("R1", "rsp_valid in reset", rsp_valid, 0);
        check("R1", "wb_valid in reset", wb_valid, 0);
        rst = 1'b0;

        // R1: empty table misses everywhere
        for (int a = 0; a < 4; a++) begin
            look(2'(a), 12'h000, "R1");
            look(2'(a), 12'hA7C, "R1");
        end

        // R6/R7: fill invalid slots in index order, no write-back
        for (int e = 0; e < NE; e++)
            refill(2'(e), 6'(e*5 + 1), 6'(e*7 + 3), 4'(e*3 + 5), 8'(e*37 + 11), 4'(e ^ 5));

        // R3/R4/R2: every block of every entry, plus homonym and wrong page
        for (int e = 0; e < NE; e++) begin
            for (int o = 0; o < NB; o++)
                look(m_asid[e], {m_vpn[e], 2'(o), 4'(e + o)}, "");
            look(2'(e + 1), {m_vpn[e], 6'h10}, "R2");
            look(m_asid[e], {6'(m_vpn[e] + 1), 6'h10}, "R2");
        end

        // R6/R7: round-robin replacement through a full wrap
        for (int k = 0; k < NE + 1; k++) begin
            oa = m_asid[m_rr]; ov = m_vpn[m_rr];
            refill(2'(k), 6'(40 + k), 6'(50 + 2*k), 4'(k*7 + 2), 8'(k*53 + 29), 4'(k*5 + 3));
            if (find(oa, ov) < 0) look(oa, {ov, 6'h00}, "R6");
        end

        // R9: every way/holder combination on every block
        for (int e = 0; e < NE; e++)
            for (int o = 0; o < NB; o++)
                for (int c = 0; c < 2; c++)
                    for (int w = 0; w < 4; w++) begin
                        upd(e, o, 1'b1, 2'(w), c[0]);
                        look(m_asid[e], {m_vpn[e], 2'(o), 4'h3}, "R9");
                    end

        // R4 then R8: invalidate, see uncached, fill, see L1
        upd(2, 1, 1'b0, 2'd2, 1'b1);
        look(m_asid[2], {m_vpn[2], 2'd1, 4'h0}, "R4");
        fill(2, 1, 2'd3);
        look(m_asid[2], {m_vpn[2], 2'd1, 4'h0}, "R8");
        upd(0, 3, 1'b1, 2'd1, 1'b1);
        fill(0, 3, 2'd2);
        look(m_asid[0], {m_vpn[0], 2'd3, 4'hF}, "R8");

        // R9: update beats fill on the same block in the same cycle
        @(negedge clk);
        fill_en = 1; fill_idx = 2'd1; fill_off = 2'd2; fill_way = 2'd0;
        upd_en = 1; upd_idx = 2'd1; upd_off = 2'd2; upd_vld = 1; upd_way = 2'd3; upd_comp = 1;
        @(negedge clk);
        fill_en = 0; upd_en = 0;
        m_set(1, 2, 1'b1, 2'd3, 1'b1);
        look(m_asid[1], {m_vpn[1], 2'd2, 4'h0}, "R9");

        // R10: same-cycle forwarding
        upd_look(3, 2, 1'b1, 2'd1, 1'b1);
        upd_look(3, 2, 1'b0, 2'd0, 1'b0);
        fill_look(3, 2, 2'd2);

        // R5: no request, no response
        @(negedge clk);
        check("R5", "rsp_valid idle", rsp_valid, 0);

        // R11: synonym retag keeps translation and location
        oa = m_asid[2]; ov = m_vpn[2];
        syn(2, 2'd3, 6'd33);
        look(oa, {ov, 6'h00}, "R11");
        for (int o = 0; o < NB; o++)
            look(2'd3, {6'd33, 2'(o), 4'h6}, "R11");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule